// File: doc/BRIEF.md
# Single-Bit Sector ECC Check and Repair

This block protects a 512-byte sector with a 24-bit single-error-correcting code. On the write side it turns a raw 32-bit parity word, produced by an external accumulator, into the 24-bit code that is stored next to the sector. The code is built from two 12-bit parity halves and is inverted, so that an erased sector of all-ones bytes yields a consistent code. It is kept as three bytes, and byte 0 is the least significant.

On the read side the host passes the stored code and the raw parity word recomputed over the data it has just read, then pulses a start input. The block XORs the two codes to get a difference and classifies it. The result is one of four cases: no error, a single flipped data bit, an error inside the code itself, or an error it cannot correct. For a data-bit error it reports the byte offset and bit index. It repairs that bit in its internal sector buffer with one read-modify-write access, and only then raises done. The host loads and reads the buffer through a simple byte port.

Top module: `sbec_repair`

## Requirements
- R1: `enc_code` equals the bitwise inverse of {`par_raw[27:16]`, `par_raw[11:0]`}. Byte k of the code sits in bits 8k+7:8k, and byte 0 is the first byte stored. For example, raw 0xFFFFFFFF gives 0x000000 and raw 0 gives 0xFFFFFF.
- R2: The recomputed code is formed from `chk_raw` by the R1 rule. When it equals `chk_stored`, the result is 0 (none) and no buffer byte changes.
- R3: A data-bit error is a difference whose bits 11:0 XOR bits 23:12 equal 0xFFF. If the difference bits 23:15, taken as a byte offset, are below SECTOR_BYTES, the result is 1 (corrected). `fix_offset` then carries that offset and `fix_bit` carries difference bits 14:12, and bit `fix_bit` of that buffer byte is inverted.
- R4: A data-bit error whose offset is not below SECTOR_BYTES gives result 2 (uncorrectable), and no buffer byte changes.
- R5: A difference with exactly one bit set gives result 1 (corrected), and no buffer byte changes.
- R6: Every other nonzero difference gives result 2 (uncorrectable).
- R7: `chk_done` is high for exactly one cycle. It rises on the first clock edge after the edge that samples `chk_start` when no bit is flipped. It rises on the second edge when a bit is flipped.
- R8: While a check is in progress, `chk_start` and host writes are ignored.
- R9: When idle, a host write stores `host_wdata` at `host_addr`. `host_rdata` shows the byte at `host_addr` one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_raw | input | 32 | Raw parity word to encode |
| enc_code | output | 24 | Code to store, byte 0 in bits 7:0 |
| chk_start | input | 1 | Starts a check when idle |
| chk_stored | input | 24 | Stored code read back, byte 0 in bits 7:0 |
| chk_raw | input | 32 | Raw parity recomputed over the read data |
| chk_done | output | 1 | One-cycle completion pulse |
| chk_result | output | 2 | 0 none, 1 corrected, 2 uncorrectable |
| fix_offset | output | 9 | Byte offset of a repaired data bit |
| fix_bit | output | 3 | Bit index of a repaired data bit |
| host_we | input | 1 | Buffer byte write strobe |
| host_addr | input | AW | Buffer byte address |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer read data, one cycle after the address |

## Verification
The encoder is combinational, so `enc_code` is compared a moment after `par_raw` is driven. After the edge that samples `chk_start`, the bench counts clock edges until `chk_done` appears and requires one edge for a check that flips nothing and two edges for a repair. Result, offset and bit are sampled in that same cycle. The bench then reads the buffer back through the host port, allowing one edge of read latency, to confirm that the target byte was flipped or that the bytes a rejected case could have touched are unchanged. The bench builds the block with a 384-byte sector, so that a decoded offset between 384 and 511 exercises the range rejection.

// File: rtl/sbec_pkg.sv
package sbec_pkg;
    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_FIXED = 2'd1,
        RES_FAIL  = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_FLIP = 2'd2
    } fsm_e;

    localparam int CODE_W = 24;
    localparam int HALF_W = 12;
    localparam int OFF_W  = 9;
    localparam int BIT_W  = 3;
endpackage

// File: rtl/sbec_pack.sv
module sbec_pack
    import sbec_pkg::*;
(
    input  logic [31:0]       raw,
    output logic [CODE_W-1:0] code
);
    // Each 12-bit parity half sits in the low part of a 16-bit lane.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign code[h*HALF_W +: HALF_W] = ~raw[h*16 +: HALF_W];
    end
endmodule

// File: rtl/sbec_classify.sv
module sbec_classify
    import sbec_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] diff,
    output res_e              kind,
    output logic              flip,
    output logic [OFF_W-1:0]  offset,
    output logic [BIT_W-1:0]  bitidx
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(SECTOR_BYTES);

    logic [HALF_W-1:0] fold;
    logic              data_err;
    logic              in_range;

    always_comb begin
        fold     = diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W];
        data_err = (fold == {HALF_W{1'b1}});
        in_range = ({1'b0, diff[CODE_W-1:HALF_W+BIT_W]} < LIMIT);
        kind     = RES_FAIL;
        flip     = 1'b0;
        offset   = '0;
        bitidx   = '0;
        if (diff == '0) begin
            kind = RES_NONE;
        end else if (data_err) begin
            if (in_range) begin
                kind   = RES_FIXED;
                flip   = 1'b1;
                offset = diff[CODE_W-1:HALF_W+BIT_W];
                bitidx = diff[HALF_W+BIT_W-1:HALF_W];
            end
        end else if ((diff & (diff - 1'b1)) == '0) begin
            kind = RES_FIXED;
        end
    end
endmodule

// File: rtl/sbec_sector_ram.sv
module sbec_sector_ram #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/sbec_repair.sv
module sbec_repair
    import sbec_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int AW = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       par_raw,
    output logic [CODE_W-1:0] enc_code,
    input  logic              chk_start,
    input  logic [CODE_W-1:0] chk_stored,
    input  logic [31:0]       chk_raw,
    output logic              chk_done,
    output logic [1:0]        chk_result,
    output logic [OFF_W-1:0]  fix_offset,
    output logic [BIT_W-1:0]  fix_bit,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    typedef struct packed {
        fsm_e              fsm;
        logic [CODE_W-1:0] diff;
        res_e              res;
        logic [OFF_W-1:0]  off;
        logic [BIT_W-1:0]  bitx;
        logic              done;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [CODE_W-1:0] calc_code;
    res_e              cls_kind;
    logic              cls_flip;
    logic [OFF_W-1:0]  cls_off;
    logic [BIT_W-1:0]  cls_bit;
    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [7:0]        ram_wd;
    logic [7:0]        ram_rd;

    sbec_pack u_enc  (.raw(par_raw), .code(enc_code));
    sbec_pack u_calc (.raw(chk_raw), .code(calc_code));

    sbec_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
        .diff   (cur_q.diff),
        .kind   (cls_kind),
        .flip   (cls_flip),
        .offset (cls_off),
        .bitidx (cls_bit)
    );

    sbec_sector_ram #(.DEPTH(SECTOR_BYTES)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_rd)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        ram_we     = 1'b0;
        ram_addr   = host_addr;
        ram_wd     = host_wdata;
        case (cur_q.fsm)
            ST_IDLE: begin
                ram_we = host_we;
                if (chk_start) begin
                    nxt_d.diff = calc_code ^ chk_stored;
                    nxt_d.fsm  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                ram_addr   = cls_off[AW-1:0];
                nxt_d.res  = cls_kind;
                nxt_d.off  = cls_off;
                nxt_d.bitx = cls_bit;
                if (cls_flip) begin
                    nxt_d.fsm = ST_FLIP;
                end else begin
                    nxt_d.fsm  = ST_IDLE;
                    nxt_d.done = 1'b1;
                end
            end
            ST_FLIP: begin
                ram_addr   = cur_q.off[AW-1:0];
                ram_we     = 1'b1;
                ram_wd     = ram_rd ^ (8'h01 << cur_q.bitx);
                nxt_d.fsm  = ST_IDLE;
                nxt_d.done = 1'b1;
            end
            default: nxt_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{fsm: ST_IDLE, diff: '0, res: RES_NONE, off: '0, bitx: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign chk_done   = cur_q.done;
    assign chk_result = cur_q.res;
    assign fix_offset = cur_q.off;
    assign fix_bit    = cur_q.bitx;
    assign host_rdata = ram_rd;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done); // R7
    AST_ZERO_DIFF_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && cur_q.diff == '0) |-> (chk_result == RES_NONE)); // R2
    AST_FLIP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.fsm == ST_FLIP) |-> ({1'b0, cur_q.off} < (OFF_W+1)'(SECTOR_BYTES))); // R4
    AST_CODE_ERR_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.fsm == ST_EVAL && $countones(cur_q.diff) == 1) |=> (cur_q.fsm != ST_FLIP)); // R5
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.fsm != ST_IDLE) |=> (cur_q.fsm != ST_EVAL)); // R8
endmodule

// File: tb/sim_sbec_repair.sv
module sim_sbec_repair;
    localparam int SB = 384;
    localparam int AW = $clog2(SB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   par_raw = '0;
    logic [23:0]   enc_code;
    logic          chk_start = 1'b0;
    logic [23:0]   chk_stored = '0;
    logic [31:0]   chk_raw = '0;
    logic          chk_done;
    logic [1:0]    chk_result;
    logic [8:0]    fix_offset;
    logic [2:0]    fix_bit;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    sbec_repair #(.SECTOR_BYTES(SB)) u0 (.*);

    function automatic logic [23:0] model_code(input logic [31:0] r);
        return ~{r[27:16], r[11:0]};
    endfunction

    function automatic logic [23:0] data_diff(input int off, input int b);
        logic [11:0] up;
        up = {off[8:0], b[2:0]};
        return {up, ~up};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        host_addr = AW'(a); host_wdata = d; host_we = 1'b1;
        @(posedge clk); #1 host_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        host_addr = AW'(a);
        @(posedge clk); #1 d = host_rdata;
    endtask

    // drive a check with a chosen difference; returns edges until done
    task automatic run(input logic [31:0] raw, input logic [23:0] diff, output int lat);
        chk_raw = raw; chk_stored = model_code(raw) ^ diff; chk_start = 1'b1;
        @(posedge clk); #1 chk_start = 1'b0;
        lat = 0;
        for (int n = 1; n <= 6; n++) begin
            @(posedge clk); #1;
            if (chk_done) begin lat = n; break; end
        end
    endtask

    task automatic t_reset;
        chk("R7 reset done", chk_done, 0);
        chk("R2 reset result", chk_result, 0);
    endtask

    task automatic t_encode;
        logic [31:0] v [4] = '{32'hFFFF_FFFF, 32'h0, 32'h1234_5678, 32'hF0A5_0C3F};
        foreach (v[i]) begin
            par_raw = v[i]; #1;
            chk("R1 encode", enc_code, model_code(v[i]));
        end
        par_raw = 32'hFFFF_FFFF; #1 chk("R1 erased", enc_code, 0);
        par_raw = 32'h0000_0001; #1 chk("R1 byte0", enc_code[7:0], 8'hFE);
    endtask

    task automatic t_host;
        logic [7:0] d;
        wr(5, 8'h3C); wr(200, 8'hC3);
        rd(5, d);   chk("R9 host rd 5", d, 8'h3C);
        rd(200, d); chk("R9 host rd 200", d, 8'hC3);
    endtask

    task automatic t_zero;
        int l; logic [7:0] d;
        wr(0, 8'h77);
        run(32'hABCD_1234, 24'h0, l);
        chk("R7 latency none", l, 1);
        chk("R2 result none", chk_result, 0);
        rd(0, d); chk("R2 byte unchanged", d, 8'h77);
    endtask

    task automatic t_fix(input int off, input int b, input logic [7:0] init);
        int l; logic [7:0] d;
        wr(off, init);
        run(32'h0F0F_5A5A, data_diff(off, b), l);
        chk("R7 latency fix", l, 2);
        chk("R3 result fixed", chk_result, 1);
        chk("R3 offset", fix_offset, off);
        chk("R3 bit", fix_bit, b);
        rd(off, d); chk("R3 flipped byte", d, init ^ (8'h01 << b));
    endtask

    task automatic t_range;
        int l; logic [7:0] d;
        wr(128, 8'h11); wr(SB-1, 8'h22);
        run(32'h1111_2222, data_diff(SB, 0), l);
        chk("R4 latency", l, 1);
        chk("R4 result fail", chk_result, 2);
        run(32'h1111_2222, data_diff(511, 7), l);
        chk("R4 result fail max", chk_result, 2);
        rd(128, d); chk("R4 byte128 unchanged", d, 8'h11);
        rd(SB-1, d); chk("R4 last byte unchanged", d, 8'h22);
    endtask

    task automatic t_codeerr;
        int l; logic [7:0] d;
        wr(4, 8'h5A); wr(2, 8'hA5);
        run(32'h0000_0000, 24'h02_0000, l);   // bit 17: would decode offset 4
        chk("R5 result fixed", chk_result, 1);
        chk("R7 latency code err", l, 1);
        run(32'h0000_0000, 24'h00_0001, l);
        chk("R5 result fixed low", chk_result, 1);
        rd(4, d); chk("R5 byte unchanged", d, 8'h5A);
        rd(2, d); chk("R5 byte2 unchanged", d, 8'hA5);
    endtask

    task automatic t_multi;
        int l;
        run(32'h4242_4242, 24'h00_0003, l);
        chk("R6 two bits", chk_result, 2);
        run(32'h4242_4242, 24'h0F_0F00, l);
        chk("R6 pattern", chk_result, 2);
        run(32'h4242_4242, 24'hFF_FFFF, l);
        chk("R6 all ones", chk_result, 2);
    endtask

    task automatic t_busy;
        int dones = 0; logic [7:0] d;
        wr(50, 8'h0F); wr(60, 8'h80);
        chk_raw = 32'h0; chk_stored = model_code(32'h0) ^ data_diff(60, 7);
        chk_start = 1'b1;
        @(posedge clk); #1;                  // sampled; now busy
        chk_stored = model_code(32'h0);      // second start would be zero diff
        host_addr = AW'(50); host_wdata = 8'hEE; host_we = 1'b1;
        @(posedge clk); #1;
        chk_start = 1'b0; host_we = 1'b0;
        for (int n = 0; n < 5; n++) begin
            if (chk_done) begin
                dones++;
                chk("R8 result kept", chk_result, 1);
            end
            @(posedge clk); #1;
        end
        chk("R8 single done", dones, 1);
        rd(50, d); chk("R8 host write ignored", d, 8'h0F);
        rd(60, d); chk("R8 flip done", d, 8'h00);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #1;
        t_reset();
        #9 rst_n = 1'b1;
        @(posedge clk); #1;
        t_encode();
        t_host();
        t_zero();
        t_fix(37, 6, 8'hA5);
        t_fix(SB-1, 0, 8'h3C);
        t_fix(0, 7, 8'hFF);
        t_range();
        t_codeerr();
        t_multi();
        t_busy();
        finish_run();
    end
endmodule